// File: doc/BRIEF.md
# Four-Cycle Unlock Command Sequencer

This block sits between a bus front end that has already turned host write strobes into single-cycle write events and the engine that drives a non-volatile byte array. A command is accepted only after three unlock writes. The first two writes carry fixed key bytes at two fixed addresses. The third carries a command byte at the first key address. A fourth write then supplies the operand address and data. That operand is latched, announced to the array engine with a one-cycle strobe, and held while the command runs.

Once the operand write is taken, the sequencer stays busy for a fixed number of clock cycles. The erase code gets a longer window than every other code. When the window ends, the sequencer returns on its own to normal read mode. While a command runs, a read-source select tells the front end where host reads come from: the array, a status byte or an identification byte.

Protocol violations do not raise a strobe. They set a sticky error flag instead. The violations are a wrong unlock write, an unknown or multi-bit command byte, too long a pause between writes, and a low-supply indication during execution. The flag stays set until a reset command completes its operand write.

Top module: `unlock_cmd_seq`

## Requirements
- R1: After reset the block is in read mode: err_flag 0, busy 0, cmd_strobe 0, rd_src 0 (array) and info_byte 00h.
- R2: The full sequence is AAh at 5555h, then 55h at 2AAAh, then a command byte at 5555h, then an operand write. Directly after the operand write, cmd_strobe is 1 for exactly one cycle. During that cycle cmd_code holds the command byte, and cmd_addr and cmd_data hold the operand. All three stay unchanged until busy falls.
- R3: A write that does not match the expected unlock address and data sets err_flag, returns the block to read mode and produces no strobe. This applies to cycles 1 to 3, and to any write made in read mode.
- R4: The only accepted command bytes are 00h reset, 01h status, 02h ID read, 04h verify-0, 08h verify-1, 10h converge, 40h program and 80h erase. Any other byte in cycle 3 sets err_flag and returns to read mode without a strobe. This includes bytes with more than one bit set, such as 03h.
- R5: Inside a sequence, each write must arrive at most GAP_CYC clock cycles after the previous one. A write exactly GAP_CYC cycles later is accepted. If GAP_CYC cycles pass with no write, err_flag is set in that cycle and the block returns to read mode.
- R6: busy is 1 for exactly CMD_CYC cycles after the operand write, or ERASE_CYC cycles for code 80h, and then the block returns to read mode. Writes made while busy is 1 have no effect: no strobe and no error.
- R7: If low_supply is 1 in any cycle while busy is 1, the command is aborted and err_flag is set. This holds even in the final cycle of the busy window. low_supply has no effect while the block is not busy.
- R8: err_flag stays set until the operand write of a reset command (code 00h) clears it. No other command clears it.
- R9: rd_src encodes 0 = array, 1 = status byte, 2 = ID byte. It is 0 whenever busy is 0. While busy, codes 00h, 01h, 10h, 40h and 80h give 1, and code 02h gives 2. Codes 04h and 08h give 1 for the first HOLD_CYC busy cycles and 0 afterwards.
- R10: When rd_src is 1, info_byte is the status byte: bit 7 = busy, bit 0 = err_flag, other bits 0. When rd_src is 2, info_byte is 52h if operand address bit 0 is 0, and DEV_CODE (default 04h) if it is 1. When rd_src is 0, info_byte is 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | One-cycle write event from the bus front end |
| wr_addr | input | ADDR_W | Address of the write event |
| wr_data | input | 8 | Data of the write event |
| low_supply | input | 1 | Supply below lockout level |
| cmd_strobe | output | 1 | One-cycle command start to the array engine |
| cmd_code | output | 8 | Command byte of the current command |
| cmd_addr | output | ADDR_W | Latched operand address |
| cmd_data | output | 8 | Latched operand data |
| rd_src | output | 2 | Read source: 0 array, 1 status, 2 ID |
| info_byte | output | 8 | Status or ID byte for host reads |
| busy | output | 1 | Command executing |
| err_flag | output | 1 | Sticky error flag |

## Verification
Two events can fall in the same clock cycle. One is the last cycle of the execution window, which would return the block cleanly to read mode. The other is a low-supply indication, which must abort the command with an error. The bench runs a program command, waits exactly CMD_CYC-1 cycles after the operand write, and raises low_supply for the one remaining cycle. It then expects err_flag 1 and busy 0. A design that let the normal timeout win would leave err_flag at 0. The gap window has a similar edge: a write placed exactly GAP_CYC cycles after its predecessor must be accepted rather than flagged.

// File: rtl/useq_pkg.sv
package useq_pkg;

   typedef enum logic [1:0] {
      SRC_ARRAY  = 2'd0,
      SRC_STATUS = 2'd1,
      SRC_ID     = 2'd2
   } rd_src_t;

   typedef enum logic [2:0] {
      ST_READ,
      ST_U1,
      ST_U2,
      ST_U3,
      ST_EXEC
   } seq_state_t;

   localparam logic [7:0] OP_RESET    = 8'h00;
   localparam logic [7:0] OP_STATUS   = 8'h01;
   localparam logic [7:0] OP_ID       = 8'h02;
   localparam logic [7:0] OP_VERIFY0  = 8'h04;
   localparam logic [7:0] OP_VERIFY1  = 8'h08;
   localparam logic [7:0] OP_CONVERGE = 8'h10;
   localparam logic [7:0] OP_PROGRAM  = 8'h40;
   localparam logic [7:0] OP_ERASE    = 8'h80;

   localparam logic [7:0] KEY_FIRST   = 8'hAA;
   localparam logic [7:0] KEY_SECOND  = 8'h55;
   localparam logic [7:0] MFR_BYTE    = 8'h52;

   function automatic logic cmd_known(input logic [7:0] c);
      case (c)
         OP_RESET, OP_STATUS, OP_ID, OP_VERIFY0, OP_VERIFY1,
         OP_CONVERGE, OP_PROGRAM, OP_ERASE: cmd_known = 1'b1;
         default:                           cmd_known = 1'b0;
      endcase
   endfunction

endpackage

// File: rtl/useq_match.sv
module useq_match
   import useq_pkg::*;
#(
   parameter int ADDR_W = 17
) (
   input  logic [1:0]        step,
   input  logic [ADDR_W-1:0] addr,
   input  logic [7:0]        data,
   output logic              step_ok
);

   localparam logic [ADDR_W-1:0] KEY_ADDR_A = ADDR_W'(16'h5555);
   localparam logic [ADDR_W-1:0] KEY_ADDR_B = ADDR_W'(16'h2AAA);

   always_comb begin
      unique case (step)
         2'd0:    step_ok = (addr == KEY_ADDR_A) && (data == KEY_FIRST);
         2'd1:    step_ok = (addr == KEY_ADDR_B) && (data == KEY_SECOND);
         2'd2:    step_ok = (addr == KEY_ADDR_A) && cmd_known(data);
         default: step_ok = 1'b0;
      endcase
   end

endmodule

// File: rtl/useq_gap.sv
module useq_gap #(
   parameter int GAP_CYC = 30000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic armed,
   input  logic wr_hit,
   output logic expire
);

   generate
      if (GAP_CYC == 0) begin : g_unlimited
         assign expire = 1'b0;
      end else begin : g_limited
         localparam int CW = $clog2(GAP_CYC + 1);
         logic [CW-1:0] idle_cnt;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               idle_cnt <= '0;
            else if (!armed || wr_hit)
               idle_cnt <= '0;
            else if (idle_cnt != CW'(GAP_CYC))
               idle_cnt <= idle_cnt + 1'b1;
         end

         assign expire = armed && !wr_hit && (idle_cnt == CW'(GAP_CYC - 1));
      end
   endgenerate

endmodule

// File: rtl/useq_exec.sv
module useq_exec #(
   parameter int CMD_CYC   = 50000,
   parameter int ERASE_CYC = 200000,
   parameter int HOLD_CYC  = 5000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic long_op,
   output logic last,
   output logic hold_over
);

   localparam int MAX_CYC = (ERASE_CYC > CMD_CYC) ? ERASE_CYC : CMD_CYC;
   localparam int CW      = $clog2(MAX_CYC + 1);

   logic [CW-1:0] run_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         run_cnt <= '0;
      else if (start)
         run_cnt <= '0;
      else if (run_cnt != CW'(MAX_CYC))
         run_cnt <= run_cnt + 1'b1;
   end

   assign last      = long_op ? (run_cnt == CW'(ERASE_CYC - 1))
                              : (run_cnt == CW'(CMD_CYC - 1));
   assign hold_over = (run_cnt >= CW'(HOLD_CYC));

endmodule

// File: rtl/unlock_cmd_seq.sv
module unlock_cmd_seq
   import useq_pkg::*;
#(
   parameter int         ADDR_W    = 17,
   parameter int         GAP_CYC   = 30000,
   parameter int         CMD_CYC   = 50000,
   parameter int         ERASE_CYC = 200000,
   parameter int         HOLD_CYC  = 5000,
   parameter logic [7:0] DEV_CODE  = 8'h04
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_valid,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [7:0]        wr_data,
   input  logic              low_supply,
   output logic              cmd_strobe,
   output logic [7:0]        cmd_code,
   output logic [ADDR_W-1:0] cmd_addr,
   output logic [7:0]        cmd_data,
   output logic [1:0]        rd_src,
   output logic [7:0]        info_byte,
   output logic              busy,
   output logic              err_flag
);

   initial begin : param_checks
      assert (ADDR_W >= 15) else $error("ADDR_W too small for unlock addresses");
      assert (CMD_CYC >= 1 && ERASE_CYC >= 1) else $error("execution windows must be nonzero");
      assert (HOLD_CYC < CMD_CYC) else $error("HOLD_CYC must be below CMD_CYC");
      assert (GAP_CYC >= 0) else $error("GAP_CYC must not be negative");
   end

   seq_state_t        state;
   logic              err_q;
   logic              strobe_q;
   logic [7:0]        code_q;
   logic [ADDR_W-1:0] addr_q;
   logic [7:0]        data_q;

   logic [1:0]        step;
   logic              step_ok;
   logic              in_unlock;
   logic              gap_expire;
   logic              exec_start;
   logic              exec_last;
   logic              hold_over;
   rd_src_t           src;

   always_comb begin
      unique case (state)
         ST_U1:   step = 2'd1;
         ST_U2:   step = 2'd2;
         default: step = 2'd0;
      endcase
   end

   assign in_unlock  = (state == ST_U1) || (state == ST_U2) || (state == ST_U3);
   assign exec_start = (state == ST_U3) && wr_valid;

   useq_match #(.ADDR_W(ADDR_W)) u_match (
      .step    (step),
      .addr    (wr_addr),
      .data    (wr_data),
      .step_ok (step_ok)
   );

   useq_gap #(.GAP_CYC(GAP_CYC)) u_gap (
      .clk    (clk),
      .rst_n  (rst_n),
      .armed  (in_unlock),
      .wr_hit (wr_valid),
      .expire (gap_expire)
   );

   useq_exec #(
      .CMD_CYC   (CMD_CYC),
      .ERASE_CYC (ERASE_CYC),
      .HOLD_CYC  (HOLD_CYC)
   ) u_exec (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (exec_start),
      .long_op   (code_q == OP_ERASE),
      .last      (exec_last),
      .hold_over (hold_over)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_READ;
         err_q    <= 1'b0;
         strobe_q <= 1'b0;
         code_q   <= '0;
         addr_q   <= '0;
         data_q   <= '0;
      end else begin
         strobe_q <= 1'b0;
         unique case (state)
            ST_READ: begin
               if (wr_valid) begin
                  if (step_ok) state <= ST_U1;
                  else         err_q <= 1'b1;
               end
            end
            ST_U1, ST_U2: begin
               if (wr_valid) begin
                  if (step_ok) begin
                     state <= (state == ST_U1) ? ST_U2 : ST_U3;
                     if (state == ST_U2) code_q <= wr_data;
                  end else begin
                     err_q <= 1'b1;
                     state <= ST_READ;
                  end
               end else if (gap_expire) begin
                  err_q <= 1'b1;
                  state <= ST_READ;
               end
            end
            ST_U3: begin
               if (wr_valid) begin
                  addr_q   <= wr_addr;
                  data_q   <= wr_data;
                  strobe_q <= 1'b1;
                  state    <= ST_EXEC;
                  if (code_q == OP_RESET) err_q <= 1'b0;
               end else if (gap_expire) begin
                  err_q <= 1'b1;
                  state <= ST_READ;
               end
            end
            ST_EXEC: begin
               if (low_supply) begin
                  err_q <= 1'b1;
                  state <= ST_READ;
               end else if (exec_last) begin
                  state <= ST_READ;
               end
            end
            default: state <= ST_READ;
         endcase
      end
   end

   always_comb begin
      src = SRC_ARRAY;
      if (state == ST_EXEC) begin
         if (code_q == OP_ID)
            src = SRC_ID;
         else if ((code_q == OP_VERIFY0 || code_q == OP_VERIFY1) && hold_over)
            src = SRC_ARRAY;
         else
            src = SRC_STATUS;
      end
   end

   always_comb begin
      unique case (src)
         SRC_STATUS: info_byte = {(state == ST_EXEC), 6'b0, err_q};
         SRC_ID:     info_byte = addr_q[0] ? DEV_CODE : MFR_BYTE;
         default:    info_byte = 8'h00;
      endcase
   end

   assign cmd_strobe = strobe_q;
   assign cmd_code   = code_q;
   assign cmd_addr   = addr_q;
   assign cmd_data   = data_q;
   assign rd_src     = src;
   assign busy       = (state == ST_EXEC);
   assign err_flag   = err_q;

endmodule

// File: rtl/useq_chk.sv
module useq_chk #(
   parameter int         ADDR_W   = 17,
   parameter logic [7:0] DEV_CODE = 8'h04
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_valid,
   input logic              low_supply,
   input logic              cmd_strobe,
   input logic [7:0]        cmd_code,
   input logic [ADDR_W-1:0] cmd_addr,
   input logic [7:0]        cmd_data,
   input logic [1:0]        rd_src,
   input logic [7:0]        info_byte,
   input logic              busy,
   input logic              err_flag
);

   assert_strobe_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_strobe |=> !cmd_strobe);

   assert_operand_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !cmd_strobe) |-> ($stable(cmd_addr) && $stable(cmd_data) && $stable(cmd_code)));

   assert_strobe_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_strobe |-> busy);

   assert_busy_ignores_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && wr_valid) |=> !cmd_strobe);

   assert_low_abort_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && low_supply) |=> (!busy && err_flag));

   assert_err_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(err_flag) |-> (cmd_strobe && cmd_code == 8'h00));

   assert_src_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_src != 2'd0) |-> busy);

   assert_id_byte_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_src == 2'd2) |-> (info_byte == 8'h52 || info_byte == DEV_CODE));

endmodule

bind unlock_cmd_seq useq_chk #(.ADDR_W(ADDR_W), .DEV_CODE(DEV_CODE)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .wr_valid   (wr_valid),
   .low_supply (low_supply),
   .cmd_strobe (cmd_strobe),
   .cmd_code   (cmd_code),
   .cmd_addr   (cmd_addr),
   .cmd_data   (cmd_data),
   .rd_src     (rd_src),
   .info_byte  (info_byte),
   .busy       (busy),
   .err_flag   (err_flag)
);

// File: tb/unlock_cmd_seq_test.sv
`timescale 1ns/1ps
module unlock_cmd_seq_test;

   localparam int AW    = 17;
   localparam int GAP   = 20;
   localparam int CMD   = 40;
   localparam int ERASE = 100;
   localparam int HOLD  = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_valid = 1'b0;
   logic [AW-1:0] wr_addr = '0;
   logic [7:0]    wr_data = '0;
   logic          low_supply = 1'b0;
   logic          cmd_strobe;
   logic [7:0]    cmd_code;
   logic [AW-1:0] cmd_addr;
   logic [7:0]    cmd_data;
   logic [1:0]    rd_src;
   logic [7:0]    info_byte;
   logic          busy;
   logic          err_flag;

   int checks = 0;
   int errors = 0;
   int n_strobe = 0;

   always #2.5 clk = ~clk;

   unlock_cmd_seq #(
      .ADDR_W(AW), .GAP_CYC(GAP), .CMD_CYC(CMD),
      .ERASE_CYC(ERASE), .HOLD_CYC(HOLD), .DEV_CODE(8'h04)
   ) uut (
      .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr),
      .wr_data(wr_data), .low_supply(low_supply), .cmd_strobe(cmd_strobe),
      .cmd_code(cmd_code), .cmd_addr(cmd_addr), .cmd_data(cmd_data),
      .rd_src(rd_src), .info_byte(info_byte), .busy(busy), .err_flag(err_flag)
   );

   always @(posedge clk) if (rst_n && cmd_strobe) n_strobe <= n_strobe + 1;

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
      wr_addr  = a;
      wr_data  = d;
      wr_valid = 1'b1;
      @(negedge clk);
      wr_valid = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic unlock(input logic [7:0] code);
      wr(17'h05555, 8'hAA);
      wr(17'h02AAA, 8'h55);
      wr(17'h05555, code);
   endtask

   task automatic wait_idle();
      int k = 0;
      while (busy && k < 1000) begin
         @(negedge clk);
         k++;
      end
   endtask

   task automatic clear_err();
      unlock(8'h00);
      wr(17'h00000, 8'h00);
      wait_idle();
   endtask

   task automatic t_reset();
      chk("R1 err_flag", int'(err_flag), 0);
      chk("R1 busy", int'(busy), 0);
      chk("R1 strobe", int'(cmd_strobe), 0);
      chk("R1 rd_src", int'(rd_src), 0);
      chk("R1 info_byte", int'(info_byte), 0);
   endtask

   task automatic t_program();
      int s0 = n_strobe;
      unlock(8'h40);
      wr(17'h01234, 8'h5A);
      chk("R2 strobe", int'(cmd_strobe), 1);
      chk("R2 code", int'(cmd_code), 8'h40);
      chk("R2 addr", int'(cmd_addr), 17'h01234);
      chk("R2 data", int'(cmd_data), 8'h5A);
      chk("R9 status src", int'(rd_src), 1);
      chk("R10 status busy", int'(info_byte), 8'h80);
      idle(1);
      chk("R2 strobe single", int'(cmd_strobe), 0);
      chk("R2 addr held", int'(cmd_addr), 17'h01234);
      idle(CMD - 2);
      chk("R6 busy last cycle", int'(busy), 1);
      idle(1);
      chk("R6 busy ends", int'(busy), 0);
      chk("R9 array after", int'(rd_src), 0);
      chk("R2 strobe count", n_strobe - s0, 1);
      chk("R2 no error", int'(err_flag), 0);
   endtask

   task automatic t_mismatch();
      int s0 = n_strobe;
      wr(17'h05555, 8'hAA);
      wr(17'h02AAA, 8'h54);
      idle(2);
      chk("R3 bad key err", int'(err_flag), 1);
      chk("R3 no strobe", n_strobe - s0, 0);
      clear_err();
      chk("R8 reset clears", int'(err_flag), 0);
      wr(17'h01000, 8'h12);
      chk("R3 stray write err", int'(err_flag), 1);
      clear_err();
   endtask

   task automatic t_badcode();
      int s0 = n_strobe;
      unlock(8'h03);
      chk("R4 multi-bit err", int'(err_flag), 1);
      chk("R4 not busy", int'(busy), 0);
      clear_err();
      unlock(8'h20);
      wr(17'h00000, 8'h00);
      chk("R4 undefined code err", int'(err_flag), 1);
      chk("R4 undefined busy", int'(busy), 0);
      idle(1);
      chk("R4 no strobe", n_strobe - s0 - 1, 0);
      clear_err();
   endtask

   task automatic t_gap();
      wr(17'h05555, 8'hAA);
      idle(GAP - 1);
      wr(17'h02AAA, 8'h55);
      chk("R5 write at limit ok", int'(err_flag), 0);
      idle(GAP - 1);
      chk("R5 still waiting", int'(err_flag), 0);
      idle(1);
      chk("R5 gap expired", int'(err_flag), 1);
      clear_err();
   endtask

   task automatic t_status_err();
      wr(17'h00007, 8'h00);
      unlock(8'h01);
      wr(17'h00000, 8'h00);
      chk("R10 status err+busy", int'(info_byte), 8'h81);
      wait_idle();
      chk("R8 status keeps err", int'(err_flag), 1);
      clear_err();
   endtask

   task automatic t_erase();
      unlock(8'h80);
      wr(17'h08000, 8'hFF);
      idle(ERASE - 1);
      chk("R6 erase busy last", int'(busy), 1);
      idle(1);
      chk("R6 erase done", int'(busy), 0);
   endtask

   task automatic t_ignore();
      int s0 = n_strobe;
      unlock(8'h40);
      wr(17'h00010, 8'h00);
      wr(17'h05555, 8'hAA);
      wr(17'h02AAA, 8'h55);
      wr(17'h05555, 8'h01);
      wr(17'h00000, 8'h00);
      wr(17'h0ABCD, 8'h99);
      chk("R6 ignored err", int'(err_flag), 0);
      chk("R6 operand kept", int'(cmd_addr), 17'h00010);
      wait_idle();
      chk("R6 one strobe", n_strobe - s0, 1);
   endtask

   task automatic t_verify();
      unlock(8'h04);
      wr(17'h00100, 8'h00);
      chk("R9 verify early", int'(rd_src), 1);
      idle(HOLD - 1);
      chk("R9 verify hold end", int'(rd_src), 1);
      idle(1);
      chk("R9 verify array", int'(rd_src), 0);
      chk("R10 array info", int'(info_byte), 0);
      wait_idle();
   endtask

   task automatic t_id();
      unlock(8'h02);
      wr(17'h00000, 8'h00);
      chk("R9 id src", int'(rd_src), 2);
      chk("R10 mfr byte", int'(info_byte), 8'h52);
      wait_idle();
      unlock(8'h02);
      wr(17'h00001, 8'h00);
      chk("R10 device byte", int'(info_byte), 8'h04);
      wait_idle();
   endtask

   task automatic t_low_supply();
      low_supply = 1'b1;
      idle(3);
      low_supply = 1'b0;
      chk("R7 idle low no effect", int'(err_flag), 0);
      unlock(8'h40);
      wr(17'h00020, 8'h11);
      idle(5);
      low_supply = 1'b1;
      @(negedge clk);
      low_supply = 1'b0;
      chk("R7 abort err", int'(err_flag), 1);
      chk("R7 abort busy", int'(busy), 0);
      clear_err();
      unlock(8'h40);
      wr(17'h00030, 8'h22);
      idle(CMD - 1);
      low_supply = 1'b1;
      @(negedge clk);
      low_supply = 1'b0;
      chk("R7 last-cycle err", int'(err_flag), 1);
      chk("R7 last-cycle busy", int'(busy), 0);
      clear_err();
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_program();
      t_mismatch();
      t_badcode();
      t_gap();
      t_status_err();
      t_erase();
      t_ignore();
      t_verify();
      t_id();
      t_low_supply();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL R6 watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule